// File: doc/BRIEF.md
# Two-Level Byte Classifier Filter

This block decides whether an 8-byte trial plaintext is worth reporting. It looks at every byte through its own programmable 256-entry, 1-bit class table. A set bit marks that byte value as acceptable at that position, for example only uppercase ASCII letters, only digits, or one exact value. The eight class bits form an 8-bit pattern. That pattern then addresses a ninth 256-entry, 1-bit combination table. The bit read from the combination table is the verdict.

With these two levels a wide range of rules can be expressed. "Every byte must match" is a combination table with only entry 0xFF set. "At least six of the eight bytes must match" sets every entry whose index has six or more ones. Mixed rules, such as a fixed two-byte header followed by letters and digits, come from giving each byte position its own class table. All nine tables together hold 2304 bits.

Software fills the tables one bit at a time through a write port that carries a table select, an address and a bit value. The lookup is pipelined in two stages. It accepts one plaintext per cycle and delivers each verdict two cycles after it was presented.

Top module: `bvc_filter`

## Requirements
- R1: Synchronous active-high reset clears all nine tables to zero and drives out_valid low, so no plaintext gives a hit until software programs the tables.
- R2: Byte position i is in_text[63-8i -: 8], so byte 0 is the most significant byte. Its value addresses class table i, which is table select value i.
- R3: Bit i of the combination index is the class bit of byte position i. out_hit is the combination table bit at that index, and the combination table is table select value 8.
- R4: When wr_en is high, the bit at wr_addr of the table named by wr_sel is set to wr_bit. wr_sel values 9 to 15 change no table.
- R5: out_valid is high exactly two cycles after in_valid was high, and one lookup can be accepted every cycle.
- R6: out_hit is low whenever out_valid is low.
- R7: A table write that lands on the same cycle as the lookup of that entry does not affect that lookup, which sees the old bit. This holds for a class table in the cycle the plaintext is presented, and for the combination table in the following cycle.
- R8: With every class table marking uppercase ASCII (0x41 to 0x5A), the "all bytes" rule (only combination entry 0xFF set) hits only when all eight bytes are uppercase. The "six or more" rule (every combination entry with at least six ones set) hits only when at least six bytes are uppercase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table bit write strobe |
| wr_sel | input | 4 | Table select: 0-7 class tables, 8 combination table |
| wr_addr | input | 8 | Bit address inside the selected table |
| wr_bit | input | 1 | Value written |
| in_valid | input | 1 | Plaintext present this cycle |
| in_text | input | 64 | Trial plaintext, byte 0 in bits 63:56 |
| out_valid | output | 1 | Verdict present this cycle |
| out_hit | output | 1 | Plaintext judged interesting |

## Verification
Fully random tables are fed with a back-to-back stream of random plaintexts and gaps in in_valid. This checks the byte-to-table wiring, the order of the pattern bits and the pipeline alignment all at once. Any swapped byte, reversed index or one-cycle slip shows up as miscompares against the bench's own lookup. Uppercase-only class tables, combined with the all-eight and six-or-more combination rules, are tried with plaintexts that have exactly 5, 6, 7 and 8 uppercase bytes, so that each threshold is checked on both sides. Directed writes that land in the same cycle as a lookup show whether the old or the new table bit is used. Writes with select codes 9 to 15, followed by a full reset, confirm that these writes change no table and that the tables are cleared.

// File: rtl/bvc_pkg.sv
package bvc_pkg;

    localparam int NUM_BYTES  = 8;
    localparam int BYTE_W     = 8;
    localparam int TEXT_W     = NUM_BYTES * BYTE_W;
    localparam int NUM_TABLES = NUM_BYTES + 1;
    localparam int SEL_W      = $clog2(NUM_TABLES);
    localparam int COMBO_SEL  = NUM_BYTES;
    localparam int ADDR_W     = (BYTE_W > NUM_BYTES) ? BYTE_W : NUM_BYTES;

    typedef logic [BYTE_W-1:0]    byte_val_t;
    typedef logic [NUM_BYTES-1:0] class_pat_t;
    typedef logic [SEL_W-1:0]     tbl_sel_t;

    // Result of the first stage: one class bit per byte position.
    typedef struct packed {
        logic       valid;
        class_pat_t pattern;
    } class_stage_t;

    // Result of the second stage.
    typedef struct packed {
        logic valid;
        logic hit;
    } verdict_t;

    // Byte position 0 sits in the most significant byte of the text.
    function automatic byte_val_t text_byte(input logic [TEXT_W-1:0] text,
                                            input int unsigned pos);
        return text[(NUM_BYTES-1-pos)*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/bvc_lut.sv
module bvc_lut #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_bit;
        end
    end

    // Combinational read: a write on the same edge is seen only afterwards.
    assign rd_bit = mem[rd_addr];

    AST_LUT_CLEARED: assert property (@(posedge clk) rst |=> (mem == '0)); // R1
    AST_LUT_WRITE:   assert property (@(posedge clk) disable iff (rst)
                         wr_en |=> (mem[$past(wr_addr)] == $past(wr_bit))); // R4
    AST_LUT_HOLD:    assert property (@(posedge clk) disable iff (rst)
                         !wr_en |=> $stable(mem)); // R4

endmodule

// File: rtl/bvc_wr_decode.sv
module bvc_wr_decode
    import bvc_pkg::*;
(
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    output logic [NUM_TABLES-1:0] tbl_we
);
    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_sel
        assign tbl_we[t] = wr_en && (wr_sel == SEL_W'(t));
    end

    always_comb begin
        AST_ONE_TABLE: assert ($onehot0(tbl_we)); // R4
        if (wr_sel > SEL_W'(COMBO_SEL)) begin
            AST_BAD_SEL_IDLE: assert (tbl_we == '0); // R4
        end
    end

endmodule

// File: rtl/bvc_class_stage.sv
module bvc_class_stage
    import bvc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BYTES-1:0] tbl_we,
    input  logic [BYTE_W-1:0]    wr_addr,
    input  logic                 wr_bit,
    input  logic                 in_valid,
    input  logic [TEXT_W-1:0]    in_text,
    output class_stage_t         s1
);
    class_pat_t class_bits;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_pos
        bvc_lut #(.ADDR_W(BYTE_W)) u_cls (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (tbl_we[b]),
            .wr_addr (wr_addr),
            .wr_bit  (wr_bit),
            .rd_addr (text_byte(in_text, b)),
            .rd_bit  (class_bits[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid   <= in_valid;
            s1.pattern <= in_valid ? class_bits : '0;
        end
    end

    AST_S1_TAKE: assert property (@(posedge clk) disable iff (rst)
                     in_valid |=> s1.valid); // R5
    AST_S1_GAP:  assert property (@(posedge clk) disable iff (rst)
                     !in_valid |=> !s1.valid); // R5

endmodule

// File: rtl/bvc_combine_stage.sv
module bvc_combine_stage
    import bvc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tbl_we,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               wr_bit,
    input  class_stage_t       s1,
    output verdict_t           verdict
);
    logic combo_bit;

    bvc_lut #(.ADDR_W(NUM_BYTES)) u_combo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_addr (wr_addr[NUM_BYTES-1:0]),
        .wr_bit  (wr_bit),
        .rd_addr (s1.pattern),
        .rd_bit  (combo_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= '0;
        end else begin
            verdict.valid <= s1.valid;
            verdict.hit   <= s1.valid && combo_bit;
        end
    end

    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
                         s1.valid |=> verdict.valid); // R5
    AST_OUT_GAP:     assert property (@(posedge clk) disable iff (rst)
                         !s1.valid |=> (!verdict.valid && !verdict.hit)); // R6

endmodule

// File: rtl/bvc_filter.sv
module bvc_filter
    import bvc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic              in_valid,
    input  logic [TEXT_W-1:0] in_text,
    output logic              out_valid,
    output logic              out_hit
);
    logic [NUM_TABLES-1:0] tbl_we;
    logic [ADDR_W-1:0]     addr_ext;
    class_stage_t          s1;
    verdict_t              verdict;

    assign addr_ext = ADDR_W'(wr_addr);

    bvc_wr_decode u_dec (
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .tbl_we (tbl_we)
    );

    bvc_class_stage u_cls (
        .clk      (clk),
        .rst      (rst),
        .tbl_we   (tbl_we[NUM_BYTES-1:0]),
        .wr_addr  (wr_addr),
        .wr_bit   (wr_bit),
        .in_valid (in_valid),
        .in_text  (in_text),
        .s1       (s1)
    );

    bvc_combine_stage u_cmb (
        .clk     (clk),
        .rst     (rst),
        .tbl_we  (tbl_we[COMBO_SEL]),
        .wr_addr (addr_ext),
        .wr_bit  (wr_bit),
        .s1      (s1),
        .verdict (verdict)
    );

    assign out_valid = verdict.valid;
    assign out_hit   = verdict.hit;

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid); // R1
    AST_NO_IDLE_HIT: assert property (@(posedge clk) disable iff (rst)
                         !out_valid |-> !out_hit); // R6

endmodule

// File: tb/bvc_filter_bench.sv
module bvc_filter_bench;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_sel;
    logic [7:0]  wr_addr;
    logic        wr_bit;
    logic        in_valid;
    logic [63:0] in_text;
    logic        out_valid;
    logic        out_hit;

    int n_checks = 0;
    int n_fail   = 0;

    bit cls [8][256];
    bit cmb [256];

    // expected pipeline: p1 presented one negedge ago, p2 two
    bit p1v, p1h, p2v, p2h;

    always #(CLK_P/2) clk = ~clk;

    bvc_filter u_bvc_filter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_bit(wr_bit), .in_valid(in_valid),
        .in_text(in_text), .out_valid(out_valid), .out_hit(out_hit)
    );

    function automatic bit model_hit(input logic [63:0] t);
        logic [7:0] idx;
        for (int i = 0; i < 8; i++) idx[i] = cls[i][t[(7-i)*8 +: 8]];
        return cmb[idx];
    endfunction

    function automatic bit is_upper(input logic [7:0] b);
        return (b >= 8'h41) && (b <= 8'h5A);
    endfunction

    function automatic logic [7:0] upper_byte();
        return 8'h41 + 8'($urandom_range(0, 25));
    endfunction

    function automatic logic [7:0] other_byte();
        logic [7:0] b = 8'($urandom);
        if (is_upper(b)) b = b ^ 8'h80;
        return b;
    endfunction

    // byte i uppercase when mask bit i is set; byte 0 is the top byte
    function automatic logic [63:0] masked_text(input logic [7:0] m);
        logic [63:0] t;
        for (int i = 0; i < 8; i++) t[(7-i)*8 +: 8] = m[i] ? upper_byte() : other_byte();
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input logic [1:0] act,
                         input logic [1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: {valid,hit} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] a, input bit b);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_addr = a; wr_bit = b;
        if (s < 4'd8) cls[s][a] = b;
        else if (s == 4'd8) cmb[a] = b;
    endtask

    task automatic wr_idle();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_model();
        for (int i = 0; i < 8; i++) for (int a = 0; a < 256; a++) cls[i][a] = 1'b0;
        for (int a = 0; a < 256; a++) cmb[a] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_model();
        p1v = 0; p1h = 0; p2v = 0; p2h = 0;
        check(out_valid == 1'b0 && out_hit == 1'b0, "R1 reset",
              {out_valid, out_hit}, 2'b00);
    endtask

    // One pipelined step: check the result of two steps ago, then drive.
    task automatic step(input bit v, input logic [63:0] t, input bit exp_h, input string req);
        @(negedge clk);
        check(out_valid == p2v && out_hit == (p2v & p2h), req,
              {out_valid, out_hit}, {p2v, p2v & p2h});
        p2v = p1v; p2h = p1h;
        p1v = v;   p1h = exp_h;
        in_valid = v; in_text = t;
    endtask

    task automatic drain(input string req);
        step(1'b0, 64'd0, 1'b0, req);
        step(1'b0, 64'd0, 1'b0, req);
        step(1'b0, 64'd0, 1'b0, req);
    endtask

    task automatic random_stream(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            logic [63:0] t = {$urandom, $urandom};
            bit v = ($urandom_range(0, 7) != 0);
            step(v, t, model_hit(t), req);
        end
        drain(req);
    endtask

    // single lookup, result checked two cycles later
    task automatic lookup1(input logic [63:0] t, input bit exp_h, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_text = t;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1 && out_hit == exp_h, req, {out_valid, out_hit}, {1'b1, exp_h});
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_addr = '0; wr_bit = 1'b0;
        in_valid = 1'b0; in_text = '0;
        do_reset();

        // R1: empty tables give no hit for any text
        random_stream(200, "R1 empty tables");

        // R2 R3 R5: random tables, back-to-back random stream
        for (int s = 0; s < 9; s++)
            for (int a = 0; a < 256; a++) wr(4'(s), 8'(a), bit'($urandom_range(0, 1)));
        wr_idle();
        random_stream(3000, "R2/R3/R5 random stream");

        // R2 R3: one class position at a time selects a distinct combo bit
        do_reset();
        for (int i = 0; i < 8; i++) begin
            wr(4'(i), 8'h00, 1'b1);
        end
        wr(4'd8, 8'h01, 1'b1);
        wr_idle();
        // only byte 0 (top byte) zero -> index 0000_0001
        lookup1(64'h00FF_FFFF_FFFF_FFFF, 1'b1, "R2 byte0 is top byte");
        lookup1(64'hFFFF_FFFF_FFFF_FF00, 1'b0, "R3 byte7 maps to index bit7");
        wr(4'd8, 8'h80, 1'b1);
        wr_idle();
        lookup1(64'hFFFF_FFFF_FFFF_FF00, 1'b1, "R3 byte7 maps to index bit7");

        // R8: all-eight uppercase rule
        do_reset();
        for (int i = 0; i < 8; i++)
            for (int a = 8'h41; a <= 8'h5A; a++) wr(4'(i), 8'(a), 1'b1);
        wr(4'd8, 8'hFF, 1'b1);
        wr_idle();
        lookup1(masked_text(8'hFF), 1'b1, "R8 all eight upper");
        for (int k = 0; k < 40; k++) begin
            logic [7:0] m = 8'($urandom);
            if (m == 8'hFF) m = 8'h7F;
            lookup1(masked_text(m), 1'b0, "R8 not all upper");
        end

        // R7: class write in the presentation cycle sees the old bit
        @(negedge clk);
        in_valid = 1'b1; in_text = 64'h4141_4141_4141_4141;
        wr_en = 1'b1; wr_sel = 4'd0; wr_addr = 8'h41; wr_bit = 1'b0;
        cls[0][8'h41] = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        check(out_valid && out_hit, "R7 class old bit", {out_valid, out_hit}, 2'b11);
        lookup1(64'h4141_4141_4141_4141, 1'b0, "R7 class new bit");
        wr(4'd0, 8'h41, 1'b1);
        wr_idle();
        // R7: combination write one cycle after presentation sees the old bit
        @(negedge clk);
        in_valid = 1'b1; in_text = 64'h4142_4344_4546_4748;
        @(negedge clk);
        in_valid = 1'b0;
        wr_en = 1'b1; wr_sel = 4'd8; wr_addr = 8'hFF; wr_bit = 1'b0;
        cmb[8'hFF] = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        check(out_valid && out_hit, "R7 combo old bit", {out_valid, out_hit}, 2'b11);
        lookup1(64'h4142_4344_4546_4748, 1'b0, "R7 combo new bit");

        // R8: six-or-more rule
        for (int a = 0; a < 256; a++) wr(4'd8, 8'(a), bit'($countones(8'(a)) >= 6));
        wr_idle();
        lookup1(masked_text(8'b1101_0111), 1'b1, "R8 six upper");
        lookup1(masked_text(8'b0111_1110), 1'b1, "R8 six upper");
        lookup1(masked_text(8'b1011_1111), 1'b1, "R8 seven upper");
        lookup1(masked_text(8'b1100_0111), 1'b0, "R8 five upper");
        for (int k = 0; k < 200; k++) begin
            logic [7:0] m = 8'($urandom);
            lookup1(masked_text(m), bit'($countones(m) >= 6), "R8 random mask");
        end

        // R4: select codes 9..15 leave every table alone
        for (int k = 0; k < 300; k++)
            wr(4'($urandom_range(9, 15)), 8'($urandom), bit'($urandom_range(0, 1)));
        wr_idle();
        for (int k = 0; k < 100; k++) begin
            logic [7:0] m = 8'($urandom);
            lookup1(masked_text(m), bit'($countones(m) >= 6), "R4 unused select");
        end
        // R4: unused selects on an empty set of tables create no hits
        do_reset();
        for (int k = 0; k < 300; k++) wr(4'($urandom_range(9, 15)), 8'($urandom), 1'b1);
        wr_idle();
        random_stream(300, "R4 unused select empty");

        // R1: reset after full programming clears everything again
        for (int s = 0; s < 9; s++)
            for (int a = 0; a < 256; a++) wr(4'(s), 8'(a), 1'b1);
        wr_idle();
        lookup1({$urandom, $urandom}, 1'b1, "R4 all ones programmed");
        do_reset();
        random_stream(300, "R1 cleared after reset");

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule